// File: doc/BRIEF.md
# Interrupt Crossbar Router

This block steers a set of level-sensitive source interrupt lines onto a smaller or equal set of output lines. The outputs feed a downstream interrupt controller, where output index i arrives as shared interrupt number i + 32. Each routable output owns a select register on a simple memory-mapped bus. The register holds the number of the source that the output passes through. Software picks a route by writing a source number into the register of the output it wants to drive.

Two masks, fixed at elaboration, set how each output behaves. A reserved output has no register and no address, and it always drives low. A bypass output is wired permanently to the source with its own index. It keeps its address slot, but it has no storage behind that slot. Register offsets are packed. Reserved outputs take no address space, so the offset of any other output is the number of lower non-reserved outputs times the register width. The register width is 1, 2 or 4 bytes, and any other value stops elaboration. Reset loads a safe select value into every routable output. Bypass and reserved outputs take no part in that load.

Top module: `irq_xbar_router`

## Requirements
- R1: Reset (rst_n low at a rising clock edge) loads SAFE_SEL into the select register of every output that is neither reserved nor bypass, and a read of that register then returns SAFE_SEL.
- R2: The register of a non-reserved output i sits at byte address (number of non-reserved outputs with index below i) × REG_BYTES. Only an exact address match selects a register.
- R3: After a write of value s to a routable output's address, from the clock edge that takes the write onward, that output equals src_irq[s] combinationally. It follows the source level with no latching.
- R4: A select value greater than or equal to N_SRC drives the routable output to 0.
- R5: A bypass output i always equals src_irq[i] (0 if i ≥ N_SRC). A write to its address changes nothing, and a read of its address returns 0.
- R6: A reserved output is always 0 and owns no address.
- R7: A write to an address that decodes to no routable output changes no register and no output. A read from such an address returns 0.
- R8: When bus_rd_en is high at a clock edge, bus_rdata presents the addressed register's current value after that edge. The value is the last one written, or SAFE_SEL after reset. In a cycle following an edge without bus_rd_en, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, taken at the rising edge |
| bus_rd_en | input | 1 | Read strobe, data returned after the edge |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_wdata | input | 8*REG_BYTES | Write data (source number) |
| bus_rdata | output | 8*REG_BYTES | Registered read data |
| src_irq | input | N_SRC | Source interrupt levels |
| irq_out | output | N_OUT | Routed interrupt levels to the downstream controller |

## Verification
On every cycle, the assertions check four things. Reserved outputs stay low and bypass outputs track their fixed source. The outputs hold steady while neither sources nor registers may change. Idle and unmapped reads return zero, and at most one output decodes from any address. The bench's scenarios are the only place to show that the packed address map lands each write on the intended output. They also show which source each select value picks, that out-of-range selects give zero, and that read-back and the reset reload of the safe value behave as required.

// File: rtl/irq_xbar_pkg.sv
// Shared types for the interrupt crossbar router.
// Assumes nothing beyond the masks handed in by the top module.
package irq_xbar_pkg;

    // Role of one output line, fixed at elaboration
    typedef enum logic [1:0] {
        XB_ROUTED   = 2'd0,
        XB_BYPASS   = 2'd1,
        XB_RESERVED = 2'd2
    } xb_kind_e;

    // Reserved takes precedence over bypass when both mask bits are set
    function automatic xb_kind_e xb_kind(input logic rsv, input logic byp);
        if (rsv)      return XB_RESERVED;
        else if (byp) return XB_BYPASS;
        else          return XB_ROUTED;
    endfunction

endpackage

// File: rtl/irq_xbar_decode.sv
// Address decoder for the select registers.
// Computes each output's packed byte offset at elaboration: reserved
// outputs take no space, all others take REG_BYTES in increasing order.
// Raises a hit only for routed outputs; bypass slots decode to nothing.
// Assumes ADDR_W < 32.
module irq_xbar_decode
    import irq_xbar_pkg::*;
#(
    parameter int              N_OUT     = 8,
    parameter int              REG_BYTES = 2,
    parameter int              ADDR_W    = 8,
    parameter logic [N_OUT-1:0] RSVD_MASK = '0,
    parameter logic [N_OUT-1:0] BYP_MASK  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_OUT-1:0]  hit
);

    // Packed byte offset of output idx
    function automatic int slot_offset(input int idx);
        int cnt;
        cnt = 0;
        for (int j = 0; j < idx; j++) begin
            if (!RSVD_MASK[j]) cnt++;
        end
        return cnt * REG_BYTES;
    endfunction

    for (genvar g = 0; g < N_OUT; g++) begin : g_slot
        localparam int       OFFSET = slot_offset(g);
        localparam xb_kind_e KIND   = xb_kind(RSVD_MASK[g], BYP_MASK[g]);
        if (KIND == XB_ROUTED) begin : g_routed
            // Exact match on the packed offset
            assign hit[g] = (32'(addr) == OFFSET);
        end else begin : g_none
            assign hit[g] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_xbar_sel_bank.sv
// Bank of per-output select registers.
// Routed outputs get a register that resets to SAFE_SEL and loads wdata
// when the write strobe and its decode hit coincide. Other outputs read
// as zero. Assumes wr_hit is at most one-hot.
module irq_xbar_sel_bank #(
    parameter int               N_OUT       = 8,
    parameter int               DATA_W      = 16,
    parameter int               SAFE_SEL    = 0,
    parameter logic [N_OUT-1:0] ROUTED_MASK = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [N_OUT-1:0]              wr_hit,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_OUT-1:0][DATA_W-1:0]  sel
);

    localparam logic [DATA_W-1:0] SAFE_V = DATA_W'(SAFE_SEL);

    for (genvar g = 0; g < N_OUT; g++) begin : g_reg
        if (ROUTED_MASK[g]) begin : g_store
            // Hold the source number for this output
            always_ff @(posedge clk) begin
                if (!rst_n)                   sel[g] <= SAFE_V;
                else if (wr_en && wr_hit[g])  sel[g] <= wdata;
            end
        end else begin : g_empty
            assign sel[g] = '0;
        end
    end

endmodule

// File: rtl/irq_xbar_src_mux.sv
// One output's source selector: passes src_irq[sel] through as a level.
// A select value at or above N_SRC yields 0. Purely combinational.
module irq_xbar_src_mux #(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 16
) (
    input  logic [N_SRC-1:0]  src_irq,
    input  logic [DATA_W-1:0] sel,
    output logic              irq
);

    // Compare against every source index; default low when none match
    always_comb begin
        irq = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (sel == DATA_W'(k)) irq = src_irq[k];
        end
    end

endmodule

// File: rtl/irq_xbar_router.sv
// Interrupt crossbar router, top level.
// Routes N_SRC level interrupts onto N_OUT outputs. Output i reaches
// the downstream controller as shared interrupt i + 32. Routed outputs
// take their source from a select register. Bypass output i is wired to
// src_irq[i]. Reserved outputs drive 0. Registers are byte-addressed,
// packed past reserved outputs. Reads are registered with one cycle of
// latency. Assumes a synchronous active-low reset held for at least
// one clock edge.
module irq_xbar_router
    import irq_xbar_pkg::*;
#(
    parameter int               N_SRC     = 16,
    parameter int               N_OUT     = 8,
    parameter int               REG_BYTES = 2,
    parameter int               ADDR_W    = 8,
    parameter logic [N_OUT-1:0] RSVD_MASK = 8'b0000_0100,
    parameter logic [N_OUT-1:0] BYP_MASK  = 8'b0001_0000,
    parameter int               SAFE_SEL  = N_SRC,
    localparam int              DATA_W    = 8 * REG_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_irq,
    output logic [N_OUT-1:0]  irq_out
);

    localparam logic [N_OUT-1:0] ROUTED_MASK = ~RSVD_MASK & ~BYP_MASK;

    // Elaboration-time parameter checks
    if (REG_BYTES != 1 && REG_BYTES != 2 && REG_BYTES != 4) begin : g_bad_width
        $error("irq_xbar_router: REG_BYTES must be 1, 2 or 4");
    end
    if (REG_BYTES == 1 && N_SRC > 256) begin : g_bad_src
        $error("irq_xbar_router: N_SRC does not fit a one-byte select");
    end
    if (ADDR_W >= 32 || N_OUT * REG_BYTES > (1 << ADDR_W)) begin : g_bad_addr
        $error("irq_xbar_router: address space too small");
    end

    logic [N_OUT-1:0]             slot_hit;
    logic [N_OUT-1:0][DATA_W-1:0] sel_q;
    logic [DATA_W-1:0]            rd_val;
    logic                         rd_hit_any;

    irq_xbar_decode #(
        .N_OUT     (N_OUT),
        .REG_BYTES (REG_BYTES),
        .ADDR_W    (ADDR_W),
        .RSVD_MASK (RSVD_MASK),
        .BYP_MASK  (BYP_MASK)
    ) u_decode (
        .addr (bus_addr),
        .hit  (slot_hit)
    );

    irq_xbar_sel_bank #(
        .N_OUT       (N_OUT),
        .DATA_W      (DATA_W),
        .SAFE_SEL    (SAFE_SEL),
        .ROUTED_MASK (ROUTED_MASK)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr_en),
        .wr_hit (slot_hit),
        .wdata  (bus_wdata),
        .sel    (sel_q)
    );

    // Per-output routing, chosen by the output's role
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        localparam xb_kind_e KIND = xb_kind(RSVD_MASK[g], BYP_MASK[g]);
        if (KIND == XB_ROUTED) begin : g_routed
            irq_xbar_src_mux #(
                .N_SRC  (N_SRC),
                .DATA_W (DATA_W)
            ) u_mux (
                .src_irq (src_irq),
                .sel     (sel_q[g]),
                .irq     (irq_out[g])
            );
        end else if (KIND == XB_BYPASS && g < N_SRC) begin : g_bypass
            assign irq_out[g] = src_irq[g];
        end else begin : g_tied
            assign irq_out[g] = 1'b0;
        end
    end

    // Read mux: OR of the (at most one) hit register
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_OUT; i++) begin
            if (slot_hit[i]) rd_val = rd_val | sel_q[i];
        end
    end

    assign rd_hit_any = |slot_hit;

    // Register read data; zero when no read is requested
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_val;
        else                bus_rdata <= '0;
    end

endmodule

// File: rtl/irq_xbar_router_chk.sv
// Assertion checker for irq_xbar_router, attached with bind.
// Observes ports plus the decode hit vector.
module irq_xbar_router_chk #(
    parameter int               N_SRC     = 16,
    parameter int               N_OUT     = 8,
    parameter int               DATA_W    = 16,
    parameter logic [N_OUT-1:0] RSVD_MASK = '0,
    parameter logic [N_OUT-1:0] BYP_MASK  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_SRC-1:0]  src_irq,
    input logic [N_OUT-1:0]  irq_out,
    input logic [N_OUT-1:0]  slot_hit,
    input logic              rd_hit_any
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        if (RSVD_MASK[g]) begin : g_rsv
            AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[g] == 1'b0); // R6
        end else if (BYP_MASK[g] && g < N_SRC) begin : g_byp
            AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[g] == src_irq[g]); // R5
        end
    end

    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit)); // R2

    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_wr_en) && $stable(src_irq)) |-> $stable(irq_out)); // R3

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd_en) |-> bus_rdata == '0); // R8

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd_en && !rd_hit_any) |-> bus_rdata == '0); // R7

endmodule

bind irq_xbar_router irq_xbar_router_chk #(
    .N_SRC     (N_SRC),
    .N_OUT     (N_OUT),
    .DATA_W    (DATA_W),
    .RSVD_MASK (RSVD_MASK),
    .BYP_MASK  (BYP_MASK)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_rdata  (bus_rdata),
    .src_irq    (src_irq),
    .irq_out    (irq_out),
    .slot_hit   (slot_hit),
    .rd_hit_any (rd_hit_any)
);

// File: tb/test_irq_xbar_router.sv
// Bench for irq_xbar_router: small configuration, near-exhaustive sweep
// of outputs x select values x source patterns, expected values computed
// from the requirements.
module test_irq_xbar_router;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 6;
    localparam int NO   = 6;
    localparam int RB   = 1;
    localparam int AW   = 8;
    localparam int DW   = 8 * RB;
    localparam logic [NO-1:0] RSV  = 6'b001000;
    localparam logic [NO-1:0] BYP  = 6'b000010;
    localparam int SAFE = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NS-1:0] src_irq = '0;
    logic [NO-1:0] irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_sel [NO];

    irq_xbar_router #(
        .N_SRC (NS), .N_OUT (NO), .REG_BYTES (RB), .ADDR_W (AW),
        .RSVD_MASK (RSV), .BYP_MASK (BYP), .SAFE_SEL (SAFE)
    ) i_irq_xbar_router (
        .clk (clk), .rst_n (rst_n), .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .src_irq (src_irq), .irq_out (irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit is_routed(input int o);
        return !RSV[o] && !BYP[o];
    endfunction

    // Packed address per R2
    function automatic int addr_of(input int o);
        int c;
        c = 0;
        for (int j = 0; j < o; j++) if (!RSV[j]) c++;
        return c * RB;
    endfunction

    function automatic logic exp_out(input int o, input logic [NS-1:0] s);
        if (RSV[o]) return 1'b0;
        if (BYP[o]) return (o < NS) ? s[o] : 1'b0;
        return (exp_sel[o] < NS) ? s[exp_sel[o]] : 1'b0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input int d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, output int d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic check_all_outputs(input string req);
        for (int o = 0; o < NO; o++) check(req, int'(irq_out[o]), int'(exp_out(o, src_irq)));
    endtask

    task automatic check_readback(input string req);
        int d;
        for (int o = 0; o < NO; o++) begin
            if (is_routed(o)) begin
                do_read(addr_of(o), d);
                check(req, d, exp_sel[o]);
            end
        end
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int o = 0; o < NO; o++) exp_sel[o] = SAFE;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int d;
        apply_reset();

        // R1: reset state of every routed register, and rdata idle
        check("R8 idle", int'(bus_rdata), 0);
        check_readback("R1 reset");
        src_irq = 6'b100000; #1;
        check_all_outputs("R1 safe route");
        @(negedge clk); check("R8 idle after read", int'(bus_rdata), 0);

        // R2/R3/R4: sweep every routed output, select 0..7, all patterns
        for (int o = 0; o < NO; o++) begin
            if (!is_routed(o)) continue;
            for (int s = 0; s < NS + 2; s++) begin
                do_write(addr_of(o), s);
                exp_sel[o] = s;
                for (int p = 0; p < (1 << NS); p++) begin
                    @(negedge clk); src_irq = NS'(p); #1;
                    check((s < NS) ? "R3 route" : "R4 out of range",
                          int'(irq_out[o]), int'(exp_out(o, src_irq)));
                    if (p % 16 == 5) begin
                        check("R5 bypass", int'(irq_out[1]), int'(src_irq[1]));
                        check("R6 reserved", int'(irq_out[3]), 0);
                    end
                end
            end
        end
        check_readback("R2 packed readback");

        // R4: wide out-of-range value
        do_write(addr_of(0), 200); exp_sel[0] = 200;
        src_irq = '1; #1;
        check("R4 wide select", int'(irq_out[0]), 0);

        // R8: distinct values read back as last written
        do_write(addr_of(0), 4); exp_sel[0] = 4;
        do_write(addr_of(2), 0); exp_sel[2] = 0;
        do_write(addr_of(4), 3); exp_sel[4] = 3;
        do_write(addr_of(5), 1); exp_sel[5] = 1;
        check_readback("R8 readback");

        // R5: write to bypass slot is ignored
        do_write(addr_of(1), 2);
        do_read(addr_of(1), d);
        check("R5 bypass read", d, 0);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); src_irq = NS'(p * 7); #1;
            check_all_outputs("R5 bypass after write");
        end
        check_readback("R5 no side effect");

        // R7: unmapped addresses ignored and read as zero
        for (int a = 5; a < 12; a++) begin
            do_write(a, 2);
            do_read(a, d);
            check("R7 unmapped read", d, 0);
        end
        do_write(255, 2);
        do_read(255, d);
        check("R7 unmapped read 255", d, 0);
        check_readback("R7 registers unchanged");
        @(negedge clk); src_irq = 6'b010101; #1;
        check_all_outputs("R7 outputs unchanged");

        // R1: reset mid-run reloads safe value
        apply_reset();
        check_readback("R1 reload");
        @(negedge clk); src_irq = 6'b100001; #1;
        check_all_outputs("R1 reload route");
        check("R6 reserved after reset", int'(irq_out[3]), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule